// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Sequencer

The sequencer turns single bus accesses into serial flash frames on a one-bit SPI link (chip-select, serial clock, one line out and one line in). A host presents an address, an access size, write data and a read/write flag under a valid/ready handshake. The block then drives one or more chip-select frames. Each frame carries an opcode byte, the frame's start address, an optional run of dummy bytes on reads, and the data bytes. Read bytes come back in a response word.

Run-time inputs select the read and write opcodes, the address length (1 to 4 bytes), the read dummy length (0 to 3 bytes) and whether data bytes run back to back inside one frame (linear) or each travel in a frame of their own. A frame carries at most four data bytes, so an 8-byte access always needs at least two frames. The serial clock is the system clock divided by `2*HALF_DIV`.

Top module: `spi_mmap_seq`

## Requirements
- R1: Out of reset, `spi_cs_no` is high, `spi_sclk_o` is low, `req_ready_o` is high and `rsp_valid_o` is low.
- R2: `spi_cs_no` falls while `spi_sclk_o` is low, before the first SCLK rising edge of a frame, and SCLK never rises while chip-select is high. The first byte of every frame is the write opcode when `req_write_i` is 1 and the read opcode otherwise.
- R3: After the opcode come `cfg_addr_len_i + 1` address bytes (code 0..3 gives 1..4 bytes). They carry the frame's start address, most significant of the sent bytes first.
- R4: On reads, `cfg_dummy_len_i` zero bytes (0..3) follow the address bytes, before any data byte.
- R5: Write frames contain no dummy bytes, whatever `cfg_dummy_len_i` holds.
- R6: `req_size_i` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. With `cfg_linear_i` = 1, a frame carries up to 4 data bytes back to back. An 8-byte access becomes two frames, and the second is addressed at the start address + 4.
- R7: With `cfg_linear_i` = 0, each data byte travels in its own frame. Byte k uses address start + k, and the address wraps at the address width.
- R8: Bytes are shifted MSB first in SPI mode 0. MOSI changes only while SCLK is low, and MISO is sampled on the rising edge. Within a frame, SCLK rising edges are exactly `2*HALF_DIV` clocks apart.
- R9: Read bytes are packed little-endian into `rsp_rdata_o`, with the first received data byte in bits 7:0. Bytes beyond the access size are zero, and a write returns zero. `rsp_valid_o` pulses for one cycle after the last frame's chip-select release.
- R10: Between two frames of one access, chip-select stays high for at least `2*HALF_DIV` clocks (one SCLK period).
- R11: `req_ready_o` is low from the cycle after acceptance until the last frame ends. A request presented while busy is not taken. Opcodes and lengths are sampled at acceptance, so a configuration change during an access does not alter its frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Access start address |
| req_size_i | input | 2 | Size code: 0/1/2/3 = 1/2/4/8 bytes |
| req_wdata_i | input | DATA_W | Write data, byte 0 in bits 7:0 |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | DATA_W | Read data, little-endian |
| cfg_rd_op_i | input | 8 | Read opcode |
| cfg_wr_op_i | input | 8 | Write opcode |
| cfg_addr_len_i | input | 2 | Address bytes minus one |
| cfg_dummy_len_i | input | 2 | Dummy bytes on reads |
| cfg_linear_i | input | 1 | 1 = bytes back to back in a frame |
| spi_cs_no | output | 1 | Chip-select, active low |
| spi_sclk_o | output | 1 | Serial clock, idle low |
| spi_mosi_o | output | 1 | Serial data to flash |
| spi_miso_i | input | 1 | Serial data from flash |

## Verification
The bench runs an 8-byte read that starts near a byte boundary. A sequencer that drops the split would hold chip-select across all eight bytes, and one that forgets to advance the address would send the wrong second-frame address. Frames are checked with a nonzero dummy count on writes, where a faulty design inserts filler bytes, and with several address lengths, where an off-by-one drops or adds an address byte. The non-linear mode runs across an address carry, which catches a design that fails to propagate the carry. The bench also rewrites the configuration and holds a second request while a transfer is in flight. A design that samples configuration late would change the frame under way, and one that ignores its own busy state would start an extra access.

// File: rtl/spi_mmap_pkg.sv
`timescale 1ns/1ps
package spi_mmap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GAP,
    ST_XFER
  } seq_state_e;
endpackage

// File: rtl/spi_clk_div.sv
`timescale 1ns/1ps
module spi_clk_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_byte_shift.sv
`timescale 1ns/1ps
module spi_byte_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] tx_i,
  input  logic       tick_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       done_o
);
  logic       active_q, sclk_q;
  logic [7:0] tx_q, rx_q;
  logic [2:0] bit_q;

  assign sclk_o = sclk_q;
  assign mosi_o = active_q & tx_q[7];
  assign rx_o   = rx_q;
  // final falling edge of the byte
  assign done_o = active_q && tick_i && sclk_q && (bit_q == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      tx_q     <= '0;
      rx_q     <= '0;
      bit_q    <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      sclk_q   <= 1'b0;
      tx_q     <= tx_i;
      bit_q    <= '0;
    end else if (active_q && tick_i) begin
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        rx_q   <= {rx_q[6:0], miso_i};
      end else begin
        sclk_q <= 1'b0;
        if (bit_q == 3'd7) active_q <= 1'b0;
        else begin
          tx_q  <= {tx_q[6:0], 1'b0};
          bit_q <= bit_q + 3'd1;
        end
      end
    end
  end

  assert_mosi_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(mosi_o));
endmodule

// File: rtl/spi_mmap_seq.sv
`timescale 1ns/1ps
module spi_mmap_seq
  import spi_mmap_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int FRAME_BYTES = 4,
  parameter int HALF_DIV    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic [7:0]        cfg_rd_op_i,
  input  logic [7:0]        cfg_wr_op_i,
  input  logic [1:0]        cfg_addr_len_i,
  input  logic [1:0]        cfg_dummy_len_i,
  input  logic              cfg_linear_i,
  output logic              spi_cs_no,
  output logic              spi_sclk_o,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i
);
  localparam int MAX_BYTES = DATA_W / 8;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);
  localparam int IDX_W     = $clog2(1 + 4 + 3 + FRAME_BYTES + 1);

  seq_state_e        st_q;
  logic              write_q, linear_q, gap_q, rsp_valid_q;
  logic [ADDR_W-1:0] addr_q, frame_addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [7:0]        opcode_q;
  logic [2:0]        abytes_q;
  logic [1:0]        dummy_q;
  logic [CNT_W-1:0]  total_q, sent_q, flen_q;
  logic [IDX_W-1:0]  idx_q;

  logic              tick, done, load, start_frame, is_data, last_byte;
  logic [7:0]        rx_byte, tx_byte;
  logic [CNT_W-1:0]  sent_nx, remaining, flen_start;
  logic [IDX_W-1:0]  hdr_len, frame_len, nxt_idx, addr_sel;
  logic [ADDR_W+31:0] addr_ext;

  spi_clk_div #(.HALF_DIV(HALF_DIV)) i_div (
    .clk_i, .rst_ni, .en_i(st_q != ST_IDLE), .tick_o(tick)
  );

  spi_byte_shift i_shift (
    .clk_i, .rst_ni, .load_i(load), .tx_i(tx_byte), .tick_i(tick),
    .miso_i(spi_miso_i), .sclk_o(spi_sclk_o), .mosi_o(spi_mosi_o),
    .rx_o(rx_byte), .done_o(done)
  );

  assign req_ready_o = (st_q == ST_IDLE);
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rdata_q;
  assign spi_cs_no   = (st_q != ST_XFER);

  always_comb begin
    hdr_len     = IDX_W'(1) + IDX_W'(abytes_q) + (write_q ? '0 : IDX_W'(dummy_q));
    frame_len   = hdr_len + IDX_W'(flen_q);
    is_data     = (idx_q >= hdr_len);
    sent_nx     = sent_q + (is_data ? CNT_W'(1) : '0);
    last_byte   = (idx_q + IDX_W'(1)) == frame_len;
    remaining   = total_q - sent_q;
    flen_start  = !linear_q ? CNT_W'(1)
                : (remaining > CNT_W'(FRAME_BYTES)) ? CNT_W'(FRAME_BYTES) : remaining;
    start_frame = (st_q == ST_GAP) && tick && gap_q;
    load        = start_frame || ((st_q == ST_XFER) && done && !last_byte);
    nxt_idx     = start_frame ? '0 : idx_q + IDX_W'(1);
    addr_ext    = {32'b0, frame_addr_q};
    addr_sel    = IDX_W'(abytes_q) - nxt_idx;
    if (nxt_idx == '0)                   tx_byte = opcode_q;
    else if (nxt_idx <= IDX_W'(abytes_q)) tx_byte = addr_ext[8*addr_sel[1:0] +: 8];
    else if (nxt_idx < hdr_len)          tx_byte = 8'h00;
    else if (write_q)                    tx_byte = wdata_q[8*sent_nx +: 8];
    else                                 tx_byte = 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      write_q      <= 1'b0;
      linear_q     <= 1'b0;
      gap_q        <= 1'b0;
      rsp_valid_q  <= 1'b0;
      addr_q       <= '0;
      frame_addr_q <= '0;
      wdata_q      <= '0;
      rdata_q      <= '0;
      opcode_q     <= '0;
      abytes_q     <= 3'd1;
      dummy_q      <= '0;
      total_q      <= '0;
      sent_q       <= '0;
      flen_q       <= '0;
      idx_q        <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          write_q  <= req_write_i;
          addr_q   <= req_addr_i;
          wdata_q  <= req_wdata_i;
          opcode_q <= req_write_i ? cfg_wr_op_i : cfg_rd_op_i;
          abytes_q <= {1'b0, cfg_addr_len_i} + 3'd1;
          dummy_q  <= cfg_dummy_len_i;
          linear_q <= cfg_linear_i;
          total_q  <= CNT_W'(1) << req_size_i;
          sent_q   <= '0;
          rdata_q  <= '0;
          gap_q    <= 1'b0;
          st_q     <= ST_GAP;
        end
        ST_GAP: if (tick) begin
          if (gap_q) begin
            st_q         <= ST_XFER;
            idx_q        <= '0;
            frame_addr_q <= addr_q + ADDR_W'(sent_q);
            flen_q       <= flen_start;
            gap_q        <= 1'b0;
          end else gap_q <= 1'b1;
        end
        ST_XFER: if (done) begin
          if (is_data && !write_q) rdata_q[8*sent_q +: 8] <= rx_byte;
          sent_q <= sent_nx;
          if (last_byte) begin
            if (sent_nx == total_q) begin
              st_q        <= ST_IDLE;
              rsp_valid_q <= 1'b1;
            end else begin
              st_q  <= ST_GAP;
              gap_q <= 1'b0;
            end
          end else idx_q <= idx_q + IDX_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_busy_cs_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_cs_no |-> !req_ready_o);
  assert_accept_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  assert_sclk_in_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sclk_o |-> !spi_cs_no);
  assert_cs_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_cs_no) |=> spi_cs_no);
  assert_rsp_after_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(!spi_cs_no));
endmodule

// File: tb/test_spi_mmap_seq.sv
`timescale 1ns/1ps
module test_spi_mmap_seq;
  localparam int HALF = 2;
  localparam longint GAP_NS = 2 * HALF * 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [63:0] rsp_rdata;
  logic [7:0]  cfg_rd = 8'h0B, cfg_wr = 8'h02;
  logic [1:0]  cfg_al = 2'd2, cfg_dl = 2'd1;
  logic        cfg_lin = 1'b1;
  logic        cs_n, sclk, mosi, miso = 1'b0;

  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  spi_mmap_seq #(.HALF_DIV(HALF)) i_spi_mmap_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .cfg_rd_op_i(cfg_rd), .cfg_wr_op_i(cfg_wr), .cfg_addr_len_i(cfg_al),
    .cfg_dummy_len_i(cfg_dl), .cfg_linear_i(cfg_lin),
    .spi_cs_no(cs_n), .spi_sclk_o(sclk), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  // flash-side model
  int frame_cnt = 0, bitn = 0, byten = 0;
  int gap_err = 0, period_err = 0, stray_err = 0, lead_err = 0;
  bit in_frame = 0, seen_hi = 0, first_rise = 1;
  longint t_hi = 0, t_rise = 0;
  logic [7:0] rxsh = '0, txsh = '0;
  logic [7:0] fbytes [0:31][0:15];
  int flen_log [0:31];

  function automatic logic [7:0] pat(int f, int j);
    return 8'(8'h3C + 8'h11 * j + 8'h07 * f);
  endfunction

  always @(negedge cs_n) if (cs_n === 1'b0) begin
    if (seen_hi && ($time - t_hi) < GAP_NS) gap_err++;
    if (sclk !== 1'b0) lead_err++;
    in_frame = 1; bitn = 0; byten = 0; first_rise = 1;
    txsh = pat(frame_cnt, 0);
    miso = txsh[7];
  end

  always @(posedge cs_n) if (in_frame) begin
    in_frame = 0;
    if (frame_cnt < 32) flen_log[frame_cnt] = byten;
    frame_cnt++;
    t_hi = $time; seen_hi = 1;
  end

  always @(posedge sclk) begin
    if (cs_n !== 1'b0) stray_err++;
    else begin
      if (!first_rise && ($time - t_rise) != GAP_NS) period_err++;
      first_rise = 0; t_rise = $time;
      rxsh = {rxsh[6:0], mosi};
      bitn++;
      if (bitn == 8) begin
        if (frame_cnt < 32 && byten < 16) fbytes[frame_cnt][byten] = rxsh;
        byten++; bitn = 0;
        txsh = pat(frame_cnt, byten);
      end
    end
  end

  always @(negedge sclk) if (cs_n === 1'b0) miso = txsh[7 - bitn];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [7:0] exp_b [0:15];
  task automatic chk_frame(string tag, int f, int len);
    chk({tag, " frame length"}, 64'(flen_log[f]), 64'(len));
    for (int k = 0; k < len; k++) chk(tag, 64'(fbytes[f][k]), 64'(exp_b[k]));
  endtask

  task automatic set_cfg(logic [7:0] rd, logic [7:0] wr, logic [1:0] al, logic [1:0] dl, logic lin);
    cfg_rd = rd; cfg_wr = wr; cfg_al = al; cfg_dl = dl; cfg_lin = lin;
  endtask

  task automatic access(logic wr, logic [31:0] a, logic [1:0] sz, logic [63:0] wd,
                        bit disturb, output logic [63:0] rd);
    logic [7:0] s_rd, s_wr; logic [1:0] s_al, s_dl; logic s_lin;
    int n;
    frame_cnt = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    n = 0;
    while (!req_ready && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);
    req_valid = 0;
    chk("R11 ready low after accept", 64'(req_ready), 64'd0);
    if (disturb) begin
      s_rd = cfg_rd; s_wr = cfg_wr; s_al = cfg_al; s_dl = cfg_dl; s_lin = cfg_lin;
      set_cfg(8'hE7, 8'hE7, ~cfg_al, ~cfg_dl, ~cfg_lin);
      req_valid = 1; req_write = ~wr; req_addr = ~a; req_size = 2'd3;
      repeat (30) @(negedge clk);
      chk("R11 ready low while busy", 64'(req_ready), 64'd0);
      req_valid = 0;
      set_cfg(s_rd, s_wr, s_al, s_dl, s_lin);
    end
    n = 0;
    while (!rsp_valid && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) begin n_bad++; n_cmp++; $display("FAIL R9 no response actual=0 expected=1"); end
    rd = rsp_rdata;
    @(negedge clk);
    chk("R9 response is a single pulse", 64'(rsp_valid), 64'd0);
    chk("R11 ready back when done", 64'(req_ready), 64'd1);
  endtask

  task automatic t_reset;
    chk("R1 cs idle high", 64'(cs_n), 64'd1);
    chk("R1 sclk idle low", 64'(sclk), 64'd0);
    chk("R1 ready high", 64'(req_ready), 64'd1);
    chk("R1 no response", 64'(rsp_valid), 64'd0);
  endtask

  // 3 addr bytes, 1 dummy, 4-byte linear read; config disturbed mid-access
  task automatic t_read_linear;
    logic [63:0] rd;
    set_cfg(8'h0B, 8'h02, 2'd2, 2'd1, 1'b1);
    access(1'b0, 32'h0012_3456, 2'd2, '0, 1'b1, rd);
    chk("R11 one access only", 64'(frame_cnt), 64'd1);
    exp_b = '{default: 8'h00};
    exp_b[0] = 8'h0B; exp_b[1] = 8'h12; exp_b[2] = 8'h34; exp_b[3] = 8'h56;
    chk_frame("R2 R3 R4 read frame", 0, 9);
    chk("R9 read data packing", rd, {32'h0, pat(0,8), pat(0,7), pat(0,6), pat(0,5)});
  endtask

  // write with nonzero dummy setting, 4 addr bytes
  task automatic t_write_nodummy;
    logic [63:0] rd;
    set_cfg(8'h0B, 8'h02, 2'd3, 2'd2, 1'b1);
    access(1'b1, 32'h89AB_CDEF, 2'd1, 64'hBEEF, 1'b0, rd);
    chk("R6 one frame", 64'(frame_cnt), 64'd1);
    exp_b = '{default: 8'h00};
    exp_b[0] = 8'h02; exp_b[1] = 8'h89; exp_b[2] = 8'hAB; exp_b[3] = 8'hCD;
    exp_b[4] = 8'hEF; exp_b[5] = 8'hEF; exp_b[6] = 8'hBE;
    chk_frame("R5 write has no dummy", 0, 7);
    chk("R9 write returns zero", rd, 64'd0);
  endtask

  // 8-byte read split in two frames
  task automatic t_read_split8;
    logic [63:0] rd;
    set_cfg(8'h0B, 8'h02, 2'd0, 2'd3, 1'b1);
    access(1'b0, 32'h0000_00FE, 2'd3, '0, 1'b0, rd);
    chk("R6 two frames", 64'(frame_cnt), 64'd2);
    exp_b = '{default: 8'h00};
    exp_b[0] = 8'h0B; exp_b[1] = 8'hFE;
    chk_frame("R6 first frame", 0, 9);
    exp_b[1] = 8'h02;
    chk_frame("R6 second frame start+4", 1, 9);
    chk("R9 R6 8-byte data", rd,
        {pat(1,8), pat(1,7), pat(1,6), pat(1,5), pat(0,8), pat(0,7), pat(0,6), pat(0,5)});
  endtask

  // per-byte frames across an address carry
  task automatic t_nonlinear_write;
    logic [63:0] rd;
    set_cfg(8'h0B, 8'h02, 2'd1, 2'd1, 1'b0);
    access(1'b1, 32'h1234_FFFE, 2'd2, 64'h4433_2211, 1'b0, rd);
    chk("R7 four frames", 64'(frame_cnt), 64'd4);
    exp_b = '{default: 8'h00};
    exp_b[0] = 8'h02;
    exp_b[1] = 8'hFF; exp_b[2] = 8'hFE; exp_b[3] = 8'h11; chk_frame("R7 frame 0", 0, 4);
    exp_b[1] = 8'hFF; exp_b[2] = 8'hFF; exp_b[3] = 8'h22; chk_frame("R7 frame 1", 1, 4);
    exp_b[1] = 8'h00; exp_b[2] = 8'h00; exp_b[3] = 8'h33; chk_frame("R7 frame 2", 2, 4);
    exp_b[1] = 8'h00; exp_b[2] = 8'h01; exp_b[3] = 8'h44; chk_frame("R7 frame 3", 3, 4);
  endtask

  task automatic t_nonlinear_read;
    logic [63:0] rd;
    set_cfg(8'h0B, 8'h02, 2'd0, 2'd0, 1'b0);
    access(1'b0, 32'h0000_0040, 2'd1, '0, 1'b0, rd);
    chk("R7 two read frames", 64'(frame_cnt), 64'd2);
    exp_b = '{default: 8'h00};
    exp_b[0] = 8'h0B; exp_b[1] = 8'h41;
    chk_frame("R7 read frame 1", 1, 3);
    chk("R7 R9 per-frame read data", rd, {48'h0, pat(1,2), pat(0,2)});
  endtask

  // single byte, no dummy, upper bytes zero
  task automatic t_read_byte;
    logic [63:0] rd;
    set_cfg(8'h03, 8'h02, 2'd3, 2'd0, 1'b1);
    access(1'b0, 32'h0102_0304, 2'd0, '0, 1'b0, rd);
    exp_b = '{default: 8'h00};
    exp_b[0] = 8'h03; exp_b[1] = 8'h01; exp_b[2] = 8'h02; exp_b[3] = 8'h03; exp_b[4] = 8'h04;
    chk_frame("R3 R4 zero dummy frame", 0, 6);
    chk("R9 upper bytes zero", rd, {56'h0, pat(0,5)});
  endtask

  task automatic t_timing;
    chk("R10 chip-select gap", 64'(gap_err), 64'd0);
    chk("R8 sclk period", 64'(period_err), 64'd0);
    chk("R2 no sclk outside frame", 64'(stray_err), 64'd0);
    chk("R2 cs before first edge", 64'(lead_err), 64'd0);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_read_linear;
    t_write_nodummy;
    t_read_split8;
    t_nonlinear_write;
    t_nonlinear_read;
    t_read_byte;
    t_timing;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule